// File: doc/BRIEF.md
# Double-Data-Rate Word Serializer and Checker

This block moves 20-bit words across a two-wire double-data-rate link in which every transition of the clock wire carries one data bit, on rising and falling edges alike. The transmit half takes a word kind and a 16-bit payload over a valid/ready stream. It adds a 2-bit preamble for the kind and two parity bits, then presents the 20 bits one per system clock. The clock wire toggles in the same cycle that each new bit appears.

The receive half registers the two wires, counts clock-wire transitions from reset, and assembles each group of 20 bits into a word. It decodes the preamble into a word kind, checks both parity bits, and presents the result for exactly one cycle. The receive side has no back-pressure because the wire cannot be stalled. A consumer must take each word in the cycle it is flagged.

On the transmit stream a word is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_valid` may wait for `tx_ready`. Payload and kind must stay stable while valid is high and ready is low. A source that holds `tx_valid` high gets back-to-back words with no idle bit between them.

Top module: `ddr_word_link`

## Requirements
- R1: While a word is being sent, `scl_o` changes level on every clock and `sda_o` presents a new bit in that same cycle. The clock wire carries one bit per transition.
- R2: Bit order on the wire is fixed. The two preamble bits come first, high preamble bit leading. Payload bits 15 down to 0 follow. The trailing parity bits come last, first parity bit before second parity bit.
- R3: Kind codes and preambles are as follows.
  - Command: code 0, preamble 01.
  - Data: code 1, preamble 11.
  - CRC: code 2, preamble 00.
  - Reserved: code 3, preamble 10.
- R4: The first parity bit is the XOR of payload bits 15, 13, …, 1. The second parity bit is the inverted XOR of payload bits 14, 12, …, 0. An all-zero payload therefore sends parity 01.
- R5: `tx_ready` is high while the transmitter is idle. It is also high in the cycle where the 20th bit is on the wire, and low otherwise. A word accepted in that last cycle starts on the next clock with no gap.
- R6: After the 20th clock-wire transition since reset or since the previous word, `rx_valid` pulses for one cycle. In loopback this pulse comes 22 clocks after the accepting edge. It carries the decoded kind and the payload.
- R7: If either received parity bit differs from the value in R4, `rx_parity_err` is high with `rx_valid`. The payload is still delivered unchanged.
- R8: A word with preamble 10 is reported as kind 3 with `rx_proto_err` high. Other preambles give `rx_proto_err` low.
- R9: During and after reset, `tx_ready` is 1 and `scl_o`, `sda_o` and `rx_valid` are 0.
- R10: When no word is being sent, `scl_o` holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one wire bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmitter takes the word on this edge |
| tx_kind | input | 2 | Word kind code (R3) |
| tx_payload | input | 16 | Payload, bit 15 sent first |
| scl_o | output | 1 | Clock wire out |
| sda_o | output | 1 | Data wire out |
| scl_i | input | 1 | Clock wire in |
| sda_i | input | 1 | Data wire in |
| rx_valid | output | 1 | One-cycle pulse with a received word |
| rx_kind | output | 2 | Decoded kind code |
| rx_payload | output | 16 | Received payload |
| rx_parity_err | output | 1 | Parity mismatch in this word |
| rx_proto_err | output | 1 | Unassigned preamble in this word |

## Verification
A wrong transmit bit counter shows up at the ports within a word. `tx_ready` rises early or late against the 20-cycle window, and the clock wire either stops toggling mid-word or keeps toggling while idle. A wrong receive edge counter or shift alignment makes every later `rx_valid` land off its 22-cycle slot, and the decoded payload comes out shifted. Swapped preamble or parity terms show up on the first word of the affected kind. Corrupted words injected directly on the input wires expose the error flags without the transmitter.

// File: rtl/ddr_word_pkg.sv
package ddr_word_pkg;
  localparam int PAYLOAD_W = 16;
  localparam int PRE_W     = 2;
  localparam int PAR_W     = 2;
  localparam int WORD_W    = PRE_W + PAYLOAD_W + PAR_W;

  typedef enum logic [1:0] {
    KIND_CMD  = 2'd0,
    KIND_DATA = 2'd1,
    KIND_CRC  = 2'd2,
    KIND_RSVD = 2'd3
  } word_kind_e;

  function automatic logic [PRE_W-1:0] preamble_of(input word_kind_e k);
    case (k)
      KIND_CMD:  return 2'b01;
      KIND_DATA: return 2'b11;
      KIND_CRC:  return 2'b00;
      default:   return 2'b10;
    endcase
  endfunction

  function automatic word_kind_e kind_of(input logic [PRE_W-1:0] p);
    case (p)
      2'b01:   return KIND_CMD;
      2'b11:   return KIND_DATA;
      2'b00:   return KIND_CRC;
      default: return KIND_RSVD;
    endcase
  endfunction

  // XOR of payload bits whose index has the given low bit
  function automatic logic lane_xor(input logic [PAYLOAD_W-1:0] d, input logic odd);
    logic r;
    r = 1'b0;
    for (int i = 0; i < PAYLOAD_W; i++)
      if ((i % 2 == 1) == odd) r = r ^ d[i];
    return r;
  endfunction

  function automatic logic [PAR_W-1:0] parity_of(input logic [PAYLOAD_W-1:0] d);
    return {lane_xor(d, 1'b1), ~lane_xor(d, 1'b0)};
  endfunction
endpackage

// File: rtl/ddr_word_tx.sv
module ddr_word_tx
  import ddr_word_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [1:0]           in_kind,
  input  logic [PAYLOAD_W-1:0] in_payload,
  output logic                 scl_o,
  output logic                 sda_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic              busy_q;
  logic [CNT_W-1:0]  sent_q;
  logic [WORD_W-1:0] shift_q;
  logic              scl_q, sda_q;
  logic [WORD_W-1:0] frame;
  logic              last_bit, take;

  assign frame    = {preamble_of(word_kind_e'(in_kind)), in_payload, parity_of(in_payload)};
  assign last_bit = (sent_q == CNT_W'(WORD_W));
  assign in_ready = !busy_q || last_bit;
  assign take     = in_valid && in_ready;
  assign scl_o    = scl_q;
  assign sda_o    = sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sent_q  <= '0;
      shift_q <= '0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
    end else if (take) begin
      busy_q  <= 1'b1;
      sent_q  <= CNT_W'(1);
      sda_q   <= frame[WORD_W-1];
      shift_q <= frame << 1;
      scl_q   <= ~scl_q;
    end else if (busy_q && !last_bit) begin
      sent_q  <= sent_q + CNT_W'(1);
      sda_q   <= shift_q[WORD_W-1];
      shift_q <= shift_q << 1;
      scl_q   <= ~scl_q;
    end else if (busy_q) begin
      busy_q  <= 1'b0;
    end
  end

  // R1
  mid_word_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_bit) |=> (scl_o != $past(scl_o)));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(scl_o));
  // R5
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
endmodule

// File: rtl/ddr_word_rx.sv
module ddr_word_rx
  import ddr_word_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 out_valid,
  output logic [1:0]           out_kind,
  output logic [PAYLOAD_W-1:0] out_payload,
  output logic                 out_parity_err,
  output logic                 out_proto_err
);
  localparam int CNT_W = $clog2(WORD_W);

  logic              scl_s, sda_s, scl_d;
  logic              edge_seen;
  logic [CNT_W-1:0]  got_q;
  logic [WORD_W-2:0] acc_q;
  logic [WORD_W-1:0] full;
  logic [PAYLOAD_W-1:0] pay;
  logic [PRE_W-1:0]  pre;
  logic [PAR_W-1:0]  par_rx;

  assign edge_seen = scl_s ^ scl_d;
  assign full      = {acc_q, sda_s};
  assign pre       = full[WORD_W-1 -: PRE_W];
  assign pay       = full[PAR_W +: PAYLOAD_W];
  assign par_rx    = full[PAR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 1'b0;
      sda_s <= 1'b0;
      scl_d <= 1'b0;
    end else begin
      scl_s <= scl_i;
      sda_s <= sda_i;
      scl_d <= scl_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got_q          <= '0;
      acc_q          <= '0;
      out_valid      <= 1'b0;
      out_kind       <= '0;
      out_payload    <= '0;
      out_parity_err <= 1'b0;
      out_proto_err  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (edge_seen) begin
        acc_q <= full[WORD_W-2:0];
        if (got_q == CNT_W'(WORD_W - 1)) begin
          got_q          <= '0;
          out_valid      <= 1'b1;
          out_kind       <= kind_of(pre);
          out_payload    <= pay;
          out_parity_err <= (par_rx != parity_of(pay));
          out_proto_err  <= (kind_of(pre) == KIND_RSVD);
        end else begin
          got_q <= got_q + CNT_W'(1);
        end
      end
    end
  end

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R8
  proto_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_proto_err) |-> (out_kind == 2'd3));
endmodule

// File: rtl/ddr_word_link.sv
module ddr_word_link
  import ddr_word_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic [1:0]           tx_kind,
  input  logic [PAYLOAD_W-1:0] tx_payload,
  output logic                 scl_o,
  output logic                 sda_o,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 rx_valid,
  output logic [1:0]           rx_kind,
  output logic [PAYLOAD_W-1:0] rx_payload,
  output logic                 rx_parity_err,
  output logic                 rx_proto_err
);
  ddr_word_tx u_tx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_valid), .in_ready(tx_ready),
    .in_kind(tx_kind), .in_payload(tx_payload),
    .scl_o(scl_o), .sda_o(sda_o)
  );

  ddr_word_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .scl_i(scl_i), .sda_i(sda_i),
    .out_valid(rx_valid), .out_kind(rx_kind), .out_payload(rx_payload),
    .out_parity_err(rx_parity_err), .out_proto_err(rx_proto_err)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> (tx_ready && !rx_valid));
endmodule

// File: tb/ddr_word_link_test.sv
module ddr_word_link_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_valid = 1'b0;
  logic [1:0] tx_kind = '0;
  logic [15:0] tx_payload = '0;
  logic tx_ready, scl_o, sda_o, rx_valid, rx_parity_err, rx_proto_err;
  logic [1:0] rx_kind;
  logic [15:0] rx_payload;
  logic inject = 1'b0, inj_scl = 1'b0, inj_sda = 1'b0;
  logic bus_scl, bus_sda;

  assign bus_scl = inject ? inj_scl : scl_o;
  assign bus_sda = inject ? inj_sda : sda_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_word_link uut (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_kind(tx_kind), .tx_payload(tx_payload),
    .scl_o(scl_o), .sda_o(sda_o), .scl_i(bus_scl), .sda_i(bus_sda),
    .rx_valid(rx_valid), .rx_kind(rx_kind), .rx_payload(rx_payload),
    .rx_parity_err(rx_parity_err), .rx_proto_err(rx_proto_err)
  );

  int checks = 0, failures = 0, cyc = 0, last_due = -1;
  logic mon_on = 1'b0, prev_scl = 1'b0;

  typedef struct { int due; logic b; } bit_t;
  typedef struct { int due; logic [1:0] k; logic [15:0] p; logic pe; logic pr; } word_t;
  bit_t  bitq[$];
  word_t expq[$];

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // R3 preamble table
  function automatic logic [1:0] pre_for(input logic [1:0] k);
    case (k) 2'd0: return 2'b01; 2'd1: return 2'b11; 2'd2: return 2'b00; default: return 2'b10; endcase
  endfunction
  function automatic logic [1:0] kind_for(input logic [1:0] p);
    case (p) 2'b01: return 2'd0; 2'b11: return 2'd1; 2'b00: return 2'd2; default: return 2'd3; endcase
  endfunction
  // R4 parity
  function automatic logic [1:0] par_for(input logic [15:0] d);
    logic a = 1'b0, b = 1'b0;
    for (int i = 1; i < 16; i += 2) a ^= d[i];
    for (int i = 0; i < 16; i += 2) b ^= d[i];
    return {a, ~b};
  endfunction

  function automatic word_t expect_of(input logic [19:0] w, input int due);
    word_t e;
    e.due = due;
    e.k   = kind_for(w[19:18]);
    e.p   = w[17:2];
    e.pe  = (w[1:0] != par_for(w[17:2]));
    e.pr  = (w[19:18] == 2'b10);
    return e;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      // R5 ready window
      chk(tx_ready == (last_due <= cyc), "R5 tx_ready", tx_ready, last_due <= cyc);
      if (bitq.size() > 0 && bitq[0].due == cyc) begin
        chk(sda_o == bitq[0].b, "R2/R4 sda bit", sda_o, bitq[0].b);
        chk(scl_o != prev_scl, "R1 scl toggle", scl_o, !prev_scl);
        void'(bitq.pop_front());
      end else begin
        chk(scl_o == prev_scl, "R10 scl idle hold", scl_o, prev_scl);
      end
      if (expq.size() > 0 && expq[0].due == cyc) begin
        chk(rx_valid, "R6 rx_valid pulse", rx_valid, 1);
        chk(rx_payload == expq[0].p, "R6 rx_payload", rx_payload, expq[0].p);
        chk(rx_kind == expq[0].k, "R3 rx_kind", rx_kind, expq[0].k);
        chk(rx_parity_err == expq[0].pe, "R7 rx_parity_err", rx_parity_err, expq[0].pe);
        chk(rx_proto_err == expq[0].pr, "R8 rx_proto_err", rx_proto_err, expq[0].pr);
        void'(expq.pop_front());
      end else begin
        chk(!rx_valid, "R6 no stray rx_valid", rx_valid, 0);
      end
      if (tx_valid && tx_ready) begin
        logic [19:0] w;
        w = {pre_for(tx_kind), tx_payload, par_for(tx_payload)};
        for (int i = 0; i < 20; i++) bitq.push_back('{cyc + 1 + i, w[19-i]});
        last_due = cyc + 20;
        expq.push_back(expect_of(w, cyc + 22));
      end
    end
    prev_scl = scl_o;
  end

  task automatic send(input logic [1:0] k, input logic [15:0] p);
    @(negedge clk);
    tx_valid = 1'b1; tx_kind = k; tx_payload = p;
    #2;
    while (!tx_ready) begin @(negedge clk); #2; end
    @(posedge clk);
  endtask

  task automatic tx_idle(input int n);
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic inj_word(input logic [19:0] w);
    @(negedge clk);
    inject = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      inj_scl = ~inj_scl;
      inj_sda = w[19-i];
      if (i == 19) expq.push_back(expect_of(w, cyc + 2));
    end
    repeat (4) @(negedge clk);
    inject = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(tx_ready == 1'b1, "R9 reset tx_ready", tx_ready, 1);
    chk(scl_o == 1'b0, "R9 reset scl_o", scl_o, 0);
    chk(sda_o == 1'b0, "R9 reset sda_o", sda_o, 0);
    chk(rx_valid == 1'b0, "R9 reset rx_valid", rx_valid, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (3) @(negedge clk);

    // R4: all-zero command payload carries parity 01
    send(2'd0, 16'h0000);
    tx_idle(30);
    // R5: back-to-back words of each kind, R8 reserved
    send(2'd1, 16'hA5C3);
    send(2'd1, 16'hFFFF);
    send(2'd2, 16'h001F);
    send(2'd3, 16'h1234);
    send(2'd0, 16'h8001);
    tx_idle(7);
    for (int i = 0; i < 8; i++) send(2'(i), 16'(i * 16'h1357 + 16'h0F0F));
    tx_idle(30);

    // R7: corrupted words injected on the wires
    inj_word({2'b11, 16'h5A5A, par_for(16'h5A5A)});
    inj_word({2'b11, 16'h5A5A, par_for(16'h5A5A) ^ 2'b10});
    inj_word({2'b01, 16'h0000, 2'b00});
    inj_word({2'b00, 16'hC001, ~par_for(16'hC001)});
    // R8: reserved preamble straight from the wire
    inj_word({2'b10, 16'h7E7E, par_for(16'h7E7E)});
    repeat (6) @(negedge clk);

    // R5: source waits, then a word after idle
    send(2'd2, 16'hBEEF);
    tx_idle(30);

    chk(expq.size() == 0, "R6 all words received", expq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule